// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps an 8-bit record of the reset that last hit the device. It also keeps the two status-word flags that tell a watchdog timeout and a power-down apart. The reset sources, the wake sources and the stack checker each present a one-cycle strobe. The register folds these strobes into its flags. Firmware reads the flags back after start-up to learn why the device restarted. Firmware can also write the register, either to clear a sticky flag or to re-arm an active-low one.

The flags differ in polarity:

- The stack overflow and stack underflow flags are active-high. Hardware sets them, and firmware writes 0 to clear them.
- The clear-pin, reset-instruction, power-on and brown-out flags are active-low. Hardware drives each one to 0 on its event, and firmware writes 1 to re-arm it.

A power-on event loads the whole register. A brown-out event also loads the register, but it keeps the power-on flag as it was. The timeout and power-down flags cannot be written by firmware. They change only on power-up, reset and wake events. For a clear-pin reset, the sleep input decides what happens to these two flags.

Top module: `rst_cause_reg`

## Requirements
- R1: An asserted `rst_n`, or a strobe on `ev_por`, gives `cause` = 8'h0C (overflow 0, underflow 0, pin 1, instruction 1, power-on 0, brown-out 0) with `tmo_flag` = 1 and `pdn_flag` = 1. This load takes effect one clock after the strobe.
- R2: A strobe on `ev_bor` (without `ev_por`) clears bits 7 and 6, sets bits 3 and 2, keeps bit 1, clears bit 0, and sets `tmo_flag` and `pdn_flag` to 1.
- R3: Bit 7 (overflow) goes to 1 on `ev_ovf`, and bit 6 (underflow) goes to 1 on `ev_unf`. A firmware write loads these bits from `fw_wdata[7]` and `fw_wdata[6]`.
- R4: Bit 3 (pin) goes to 0 on `ev_pin`, and bit 2 (instruction) goes to 0 on `ev_rinst`. A firmware write loads bits 3 to 0 from `fw_wdata[3:0]`.
- R5: Bits 5 and 4 of `cause` always read 0, whatever is written.
- R6: When a hardware event and a firmware write touch the same bit in the same cycle, the bit takes the hardware value. A written bit that no event touches takes the written value.
- R7: `ev_pin` with `asleep` = 1 sets `tmo_flag` to 1 and `pdn_flag` to 0. `ev_pin` with `asleep` = 0 leaves both flags unchanged.
- R8: `ev_wdt_rst` clears `tmo_flag` and leaves `pdn_flag` unchanged. `ev_wdt_wake` clears both flags.
- R9: `ev_int_wake` sets `tmo_flag` to 1 and clears `pdn_flag`. When several of these flag events coincide, the priority is `ev_wdt_wake`, then `ev_wdt_rst`, then the clear-pin event, then `ev_int_wake`.
- R10: The power-on and brown-out loads override every simultaneous firmware write and every other event. Power-on takes precedence over brown-out.
- R11: With no strobe and no write, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, gives the power-on state |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_pin | input | 1 | External clear-pin reset strobe |
| ev_rinst | input | 1 | Reset-instruction strobe |
| ev_ovf | input | 1 | Stack overflow reset strobe |
| ev_unf | input | 1 | Stack underflow reset strobe |
| ev_wdt_rst | input | 1 | Watchdog timeout reset strobe |
| ev_wdt_wake | input | 1 | Watchdog wake-from-sleep strobe |
| ev_int_wake | input | 1 | Interrupt wake-from-sleep strobe |
| asleep | input | 1 | Device is in sleep |
| fw_we | input | 1 | Firmware write enable |
| fw_wdata | input | 8 | Firmware write data |
| cause | output | 8 | Reset cause register read value |
| tmo_flag | output | 1 | Timeout flag of the status word |
| pdn_flag | output | 1 | Power-down flag of the status word |

## Verification
The hardest state to reach is a brown-out that finds the power-on flag at 1 and both status flags at 0. The bench sets up this state in three steps:

1. A firmware write re-arms the power-on flag.
2. A watchdog wake clears both status flags.
3. The brown-out strobe is then driven together with an all-ones write and an overflow strobe.

This shows that the brown-out load preserves the power-on flag and overrides both the write and the other event. The sleep-dependent clear-pin case is covered from both sleep states, starting from flag values that make each outcome visible.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_por,
  input  logic       ev_bor,
  input  logic       ev_pin,
  input  logic       ev_rinst,
  input  logic       ev_ovf,
  input  logic       ev_unf,
  input  logic       ev_wdt_rst,
  input  logic       ev_wdt_wake,
  input  logic       ev_int_wake,
  input  logic       asleep,
  input  logic       fw_we,
  input  logic [7:0] fw_wdata,
  output logic [7:0] cause,
  output logic       tmo_flag,
  output logic       pdn_flag
);
  logic ovf_q, unf_q, pin_q, ri_q, pon_q, bo_q, tmo_q, pd_q;
  logic [1:0] rsvd;

  assign rsvd     = fw_wdata[5:4] & 2'b00;
  assign cause    = {ovf_q, unf_q, rsvd, pin_q, ri_q, pon_q, bo_q};
  assign tmo_flag = tmo_q;
  assign pdn_flag = pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ovf_q, unf_q, pin_q, ri_q, pon_q, bo_q} <= 6'b001100;
      tmo_q <= 1'b1;
      pd_q  <= 1'b1;
    end else if (ev_por) begin
      {ovf_q, unf_q, pin_q, ri_q, pon_q, bo_q} <= 6'b001100;
      tmo_q <= 1'b1;
      pd_q  <= 1'b1;
    end else if (ev_bor) begin
      {ovf_q, unf_q, pin_q, ri_q} <= 4'b0011;
      bo_q  <= 1'b0;
      tmo_q <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      if (ev_ovf)     ovf_q <= 1'b1;
      else if (fw_we) ovf_q <= fw_wdata[7];
      if (ev_unf)     unf_q <= 1'b1;
      else if (fw_we) unf_q <= fw_wdata[6];
      if (ev_pin)     pin_q <= 1'b0;
      else if (fw_we) pin_q <= fw_wdata[3];
      if (ev_rinst)   ri_q  <= 1'b0;
      else if (fw_we) ri_q  <= fw_wdata[2];
      if (fw_we) begin
        pon_q <= fw_wdata[1];
        bo_q  <= fw_wdata[0];
      end
      if (ev_wdt_wake) begin
        tmo_q <= 1'b0;
        pd_q  <= 1'b0;
      end else if (ev_wdt_rst) begin
        tmo_q <= 1'b0;
      end else if (ev_pin && asleep) begin
        tmo_q <= 1'b1;
        pd_q  <= 1'b0;
      end else if (ev_pin) begin
        tmo_q <= tmo_q;
      end else if (ev_int_wake) begin
        tmo_q <= 1'b1;
        pd_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rst_cause_reg_sva.sv
module rst_cause_reg_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_por,
  input logic       ev_bor,
  input logic       ev_pin,
  input logic       ev_rinst,
  input logic       ev_ovf,
  input logic       ev_unf,
  input logic       ev_wdt_rst,
  input logic       ev_wdt_wake,
  input logic       ev_int_wake,
  input logic       asleep,
  input logic       fw_we,
  input logic [7:0] cause,
  input logic       tmo_flag,
  input logic       pdn_flag
);
  logic hw_load;
  assign hw_load = ev_por || ev_bor;

  p_por_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> (cause == 8'h0C) && tmo_flag && pdn_flag);

  p_bor_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por) |=> (cause[7:6] == 2'b00) && (cause[3:2] == 2'b11)
      && !cause[0] && (cause[1] == $past(cause[1])) && tmo_flag && pdn_flag);

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && !hw_load) |=> cause[7]);

  p_pin_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pin && !hw_load) |=> !cause[3]);

  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cause[5:4] == 2'b00);

  p_wdt_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_rst && !ev_wdt_wake && !hw_load) |=> !tmo_flag && (pdn_flag == $past(pdn_flag)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_por || ev_bor || ev_pin || ev_rinst || ev_ovf || ev_unf || ev_wdt_rst
      || ev_wdt_wake || ev_int_wake || fw_we)
    |=> $stable(cause) && $stable(tmo_flag) && $stable(pdn_flag));
endmodule

bind rst_cause_reg rst_cause_reg_sva sva_i (
  .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_pin(ev_pin),
  .ev_rinst(ev_rinst), .ev_ovf(ev_ovf), .ev_unf(ev_unf), .ev_wdt_rst(ev_wdt_rst),
  .ev_wdt_wake(ev_wdt_wake), .ev_int_wake(ev_int_wake), .asleep(asleep),
  .fw_we(fw_we), .cause(cause), .tmo_flag(tmo_flag), .pdn_flag(pdn_flag)
);

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_por = 0, ev_bor = 0, ev_pin = 0, ev_rinst = 0, ev_ovf = 0, ev_unf = 0;
  logic ev_wdt_rst = 0, ev_wdt_wake = 0, ev_int_wake = 0, asleep = 0, fw_we = 0;
  logic [7:0] fw_wdata = 8'h00;
  logic [7:0] cause;
  logic tmo_flag, pdn_flag;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_pin(ev_pin),
    .ev_rinst(ev_rinst), .ev_ovf(ev_ovf), .ev_unf(ev_unf), .ev_wdt_rst(ev_wdt_rst),
    .ev_wdt_wake(ev_wdt_wake), .ev_int_wake(ev_int_wake), .asleep(asleep),
    .fw_we(fw_we), .fw_wdata(fw_wdata), .cause(cause), .tmo_flag(tmo_flag),
    .pdn_flag(pdn_flag)
  );

  task automatic chk(input string req, input logic [7:0] cexp, input logic [1:0] fexp);
    checks++;
    if (cause !== cexp || {tmo_flag, pdn_flag} !== fexp) begin
      failures++;
      $display("FAIL %s cause=%h tmo/pd=%b expected cause=%h tmo/pd=%b",
               req, cause, {tmo_flag, pdn_flag}, cexp, fexp);
    end
  endtask

  task automatic idle_all;
    {ev_por, ev_bor, ev_pin, ev_rinst, ev_ovf, ev_unf} = '0;
    {ev_wdt_rst, ev_wdt_wake, ev_int_wake, fw_we} = '0;
  endtask

  task automatic step;
    @(negedge clk);
    idle_all();
  endtask

  task automatic fw_write(input logic [7:0] d);
    @(negedge clk);
    fw_we = 1; fw_wdata = d;
    step();
  endtask

  task automatic t_reset;
    chk("R1 reset state", 8'h0C, 2'b11);
  endtask

  task automatic t_write;
    fw_write(8'hFF);
    chk("R5 unimplemented bits after write", 8'hCF, 2'b11);
    fw_write(8'h00);
    chk("R3 firmware clears all", 8'h00, 2'b11);
  endtask

  task automatic t_events;
    fw_write(8'h0F);
    chk("R4 firmware rearm", 8'h0F, 2'b11);
    @(negedge clk); ev_ovf = 1; step();
    chk("R3 overflow set", 8'h8F, 2'b11);
    @(negedge clk); ev_unf = 1; step();
    chk("R3 underflow set", 8'hCF, 2'b11);
    @(negedge clk); ev_pin = 1; step();
    chk("R4 R7 pin awake", 8'hC7, 2'b11);
    @(negedge clk); ev_rinst = 1; step();
    chk("R4 instruction clear", 8'hC3, 2'b11);
    repeat (3) step();
    chk("R11 hold", 8'hC3, 2'b11);
  endtask

  task automatic t_conflict;
    @(negedge clk); fw_we = 1; fw_wdata = 8'h0F; ev_ovf = 1; ev_pin = 1; step();
    chk("R6 hardware beats write", 8'h87, 2'b11);
  endtask

  task automatic t_flags;
    fw_write(8'h0F);
    @(negedge clk); ev_wdt_rst = 1; step();
    chk("R8 watchdog reset", 8'h0F, 2'b01);
    @(negedge clk); ev_pin = 1; asleep = 0; step();
    chk("R7 pin awake keeps flags", 8'h07, 2'b01);
    @(negedge clk); ev_int_wake = 1; step();
    chk("R9 interrupt wake", 8'h07, 2'b10);
    @(negedge clk); ev_wdt_wake = 1; step();
    chk("R8 watchdog wake", 8'h07, 2'b00);
    @(negedge clk); ev_pin = 1; asleep = 1; step();
    asleep = 0;
    chk("R7 pin in sleep", 8'h07, 2'b10);
    @(negedge clk); ev_int_wake = 1; ev_wdt_rst = 1; step();
    chk("R9 priority watchdog over interrupt", 8'h07, 2'b00);
  endtask

  task automatic t_bor;
    fw_write(8'h0B);
    @(negedge clk); ev_ovf = 1; ev_wdt_wake = 1; step();
    chk("R3 setup before brown-out", 8'h8B, 2'b00);
    @(negedge clk); ev_bor = 1; ev_ovf = 1; fw_we = 1; fw_wdata = 8'hFF; step();
    chk("R2 R10 brown-out keeps power-on 1", 8'h0E, 2'b11);
    fw_write(8'hC0);
    @(negedge clk); ev_bor = 1; step();
    chk("R2 brown-out keeps power-on 0", 8'h0C, 2'b11);
  endtask

  task automatic t_por;
    fw_write(8'hCF);
    @(negedge clk); ev_wdt_wake = 1; step();
    @(negedge clk); ev_por = 1; ev_bor = 1; ev_ovf = 1; ev_wdt_rst = 1;
    fw_we = 1; fw_wdata = 8'hFF; step();
    chk("R1 R10 power-on event load", 8'h0C, 2'b11);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_events();
    t_conflict();
    t_flags();
    t_bor();
    t_por();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule